// File: doc/BRIEF.md
# Multi-Block DMA Channel Sequencer

This block is the per-channel control for a DMA channel that moves data as a chain of blocks. At the end of each block it decides what the channel does next. It takes four configuration bits: linked-list pointer enables for the source and destination sides, and address auto-reload enables for the source and destination sides. From these it works out a transfer-mode row number. Based on that row, it either starts the next block at once, waits for software to acknowledge the block interrupt, asks the datapath for a status write-back, or ends the transfer.

The data mover, the descriptor fetch and the register decode are outside this block. The data mover reports each finished block with a destination-side done pulse and is told to begin a block with a one-cycle start pulse. Software is represented by a clear-block strobe. The status write-back is a request held high until an acknowledge arrives. The block-complete interrupt is a pending flag, gated by the channel's mask bit.

Top module: `dmaseq_channel`

## Requirements
- R1: `mode_row` shows the row computed from {src_ll, dst_ll, src_rl, dst_rl} as follows:
  - 0000 gives row 1, or row 5 when `cfg_stat_en` is 1;
  - 0001 gives 2, 0010 gives 3 and 0011 gives 4;
  - 0100 gives 6 and 0110 gives 7;
  - 1000 gives 8 and 1001 gives 9;
  - 1100 gives 10.
- R2: At a block end in row 1 or row 5 the transfer terminates. `xfer_done` is high for exactly one cycle and `ch_active` is low from then on.
- R3: Terminating in row 5 raises `status_req`, and holds it until `status_ack`, before `xfer_done`. Terminating in row 1 never raises `status_req`.
- R4: In rows 6, 8 and 10, the cycle after the block end is handled shows `blk_start` without any stall.
- R5: In rows 2, 3, 4, 7 and 9, the channel enters the stalled state (`stalled`=1) after the block end when `cfg_int_en`=1 and `blk_mask`=0.
- R6: While stalled, no block starts until `clr_blk`. That strobe clears `blk_irq`, and `blk_start` follows in the next cycle.
- R7: In rows 2, 3, 4, 7 and 9 with `cfg_int_en`=0 or `blk_mask`=1, the channel continues with `blk_start` and does not stall.
- R8: The pending block interrupt is set only by `blk_dst_done` while a block runs with `cfg_int_en`=1. `blk_src_done` never sets it. `blk_irq` is the pending flag gated by `blk_mask`=0.
- R9: In rows 2 to 4, blocks keep repeating until software has cleared both reload bits. The next block end then terminates.
- R10: `clr_blk` while not stalled only clears the pending interrupt. The channel's state and outputs are otherwise unchanged.
- R11: Reserved combinations (any other value of the four bits) give row 1.
- R12: After reset the channel is idle, with every output low except `mode_row`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Pulse that starts a transfer from idle |
| cfg_src_ll | input | 1 | Source linked-list enable |
| cfg_dst_ll | input | 1 | Destination linked-list enable |
| cfg_src_rl | input | 1 | Source address auto-reload enable |
| cfg_dst_rl | input | 1 | Destination address auto-reload enable |
| cfg_stat_en | input | 1 | Status write-back enable for a single-block configuration |
| cfg_int_en | input | 1 | Channel interrupt enable |
| blk_mask | input | 1 | Block interrupt mask, 1 masks |
| blk_src_done | input | 1 | Pulse: source reads of the block finished |
| blk_dst_done | input | 1 | Pulse: block completed to the destination |
| clr_blk | input | 1 | Software clear-block strobe |
| status_ack | input | 1 | Status write-back completed |
| blk_start | output | 1 | One-cycle pulse: begin next block |
| stalled | output | 1 | Channel waiting for clear-block |
| status_req | output | 1 | Status write-back request |
| xfer_done | output | 1 | One-cycle pulse on termination |
| ch_active | output | 1 | Channel enabled |
| blk_irq | output | 1 | Block-complete interrupt |
| mode_row | output | 4 | Current transfer-mode row (1 to 10) |

## Verification
The assertions check several rules on every cycle:
- the single-cycle done pulse and the held status request;
- that a stall is never left without the clear strobe;
- that a stall begins only with the interrupt unmasked;
- that the pending interrupt rises only at a destination-side block end.

Other behaviours only the bench can show. These are the full row mapping across all thirty-two configurations, the chosen end-of-block action for every combination of enable and mask, the reload-clearing sequence that ends a repeating transfer, and the fact that a stray clear strobe leaves the sequencing untouched.

// File: rtl/dmaseq_pkg.sv
package dmaseq_pkg;
  localparam int ROW_W = 4;
  localparam int ROW_MAX = 10;

  typedef logic [ROW_W-1:0] row_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RUN, ST_BLK_END, ST_STALL, ST_STATUS_WB, ST_DONE
  } seq_state_e;

  typedef enum logic [1:0] {
    KIND_TERMINATE, KIND_CONTINUE, KIND_RELOAD
  } row_kind_e;

  typedef struct packed {
    logic src_ll;
    logic dst_ll;
    logic src_rl;
    logic dst_rl;
    logic stat_en;
  } chan_cfg_t;
endpackage

// File: rtl/dmaseq_row_classify.sv
module dmaseq_row_classify
  import dmaseq_pkg::*;
(
  input  chan_cfg_t cfg_i,
  output row_t      row_o,
  output row_kind_e kind_o,
  output logic      stat_wb_o
);
  always_comb begin
    case ({cfg_i.src_ll, cfg_i.dst_ll, cfg_i.src_rl, cfg_i.dst_rl})
      4'b0000: row_o = cfg_i.stat_en ? row_t'(5) : row_t'(1);
      4'b0001: row_o = row_t'(2);
      4'b0010: row_o = row_t'(3);
      4'b0011: row_o = row_t'(4);
      4'b0100: row_o = row_t'(6);
      4'b0110: row_o = row_t'(7);
      4'b1000: row_o = row_t'(8);
      4'b1001: row_o = row_t'(9);
      4'b1100: row_o = row_t'(10);
      default: row_o = row_t'(1);   // reserved combinations, R11
    endcase
  end

  always_comb begin
    case (row_o)
      row_t'(2), row_t'(3), row_t'(4), row_t'(7), row_t'(9): kind_o = KIND_RELOAD;
      row_t'(6), row_t'(8), row_t'(10):                      kind_o = KIND_CONTINUE;
      default:                                               kind_o = KIND_TERMINATE;
    endcase
  end

  assign stat_wb_o = (row_o == row_t'(5));
endmodule

// File: rtl/dmaseq_irq_flag.sv
module dmaseq_irq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic blk_end_i,
  input  logic src_done_i,
  input  logic int_en_i,
  input  logic mask_i,
  input  logic clr_i,
  output logic pend_o,
  output logic irq_o
);
  logic pend_q, pend_d, pend_en;

  always_comb begin
    pend_en = (blk_end_i && int_en_i) || clr_i;
    pend_d  = blk_end_i && int_en_i;   // a set wins over a same-cycle clear
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_q <= 1'b0;
    else if (pend_en) pend_q <= pend_d;
  end

  assign pend_o = pend_q;
  assign irq_o  = pend_q && !mask_i;

  // R8: the pending flag rises only after a destination-side block end
  p_pend_from_dst_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_q) |-> $past(blk_end_i));

  // R8: source-side completion alone leaves the flag clear
  p_src_no_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (src_done_i && !blk_end_i && !pend_q) |=> !pend_q);

  // R10: a clear with no concurrent set empties the flag
  p_clear_empties_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !(blk_end_i && int_en_i)) |=> !pend_q);
endmodule

// File: rtl/dmaseq_fsm.sv
module dmaseq_fsm
  import dmaseq_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start_i,
  input  logic      dst_done_i,
  input  logic      clr_i,
  input  logic      ack_i,
  input  row_kind_e kind_i,
  input  logic      stat_wb_i,
  input  logic      stall_ok_i,
  output logic      blk_end_o,
  output logic      blk_start_o,
  output logic      stalled_o,
  output logic      status_req_o,
  output logic      done_o,
  output logic      active_o
);
  seq_state_e state_q, state_d;
  logic       start_q, start_d, state_en;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:      if (start_i) state_d = ST_RUN;
      ST_RUN:       if (dst_done_i) state_d = ST_BLK_END;
      ST_BLK_END: begin
        case (kind_i)
          KIND_CONTINUE: state_d = ST_RUN;
          KIND_RELOAD:   state_d = stall_ok_i ? ST_STALL : ST_RUN;
          default:       state_d = stat_wb_i ? ST_STATUS_WB : ST_DONE;
        endcase
      end
      ST_STALL:     if (clr_i) state_d = ST_RUN;
      ST_STATUS_WB: if (ack_i) state_d = ST_DONE;
      ST_DONE:      state_d = ST_IDLE;
      default:      state_d = ST_IDLE;
    endcase
    state_en = (state_d != state_q);
    start_d  = (state_d == ST_RUN) && (state_q != ST_RUN);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        state_q <= ST_IDLE;
    else if (state_en) state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) start_q <= 1'b0;
    else        start_q <= start_d;
  end

  assign blk_end_o    = (state_q == ST_RUN) && dst_done_i;
  assign blk_start_o  = start_q;
  assign stalled_o    = (state_q == ST_STALL);
  assign status_req_o = (state_q == ST_STATUS_WB);
  assign done_o       = (state_q == ST_DONE);
  assign active_o     = (state_q != ST_IDLE) && (state_q != ST_DONE);

  // R2: the termination pulse lasts one cycle
  p_done_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R2: a terminating row ends in write-back or done
  p_term_row_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_BLK_END && kind_i == KIND_TERMINATE) |=> (done_o || status_req_o));

  // R3: the write-back request holds until acknowledged
  p_status_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (status_req_o && !ack_i) |=> status_req_o);

  // R4: linked-list rows go on to the next block
  p_continue_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_BLK_END && kind_i == KIND_CONTINUE) |=> (blk_start_o && !stalled_o));

  // R5: a stall begins only with the interrupt enabled and unmasked
  p_stall_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stalled_o) |-> $past(stall_ok_i));

  // R6: the stall is left only through the clear strobe
  p_stall_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (stalled_o && !clr_i) |=> stalled_o);

  p_outputs_exclusive_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({blk_start_o, stalled_o, status_req_o, done_o}));
endmodule

// File: rtl/dmaseq_channel.sv
module dmaseq_channel
  import dmaseq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             cfg_src_ll,
  input  logic             cfg_dst_ll,
  input  logic             cfg_src_rl,
  input  logic             cfg_dst_rl,
  input  logic             cfg_stat_en,
  input  logic             cfg_int_en,
  input  logic             blk_mask,
  input  logic             blk_src_done,
  input  logic             blk_dst_done,
  input  logic             clr_blk,
  input  logic             status_ack,
  output logic             blk_start,
  output logic             stalled,
  output logic             status_req,
  output logic             xfer_done,
  output logic             ch_active,
  output logic             blk_irq,
  output logic [ROW_W-1:0] mode_row
);
  chan_cfg_t cfg;
  row_t      row;
  row_kind_e kind;
  logic      stat_wb, stall_ok, blk_end, pend;

  assign cfg = '{src_ll: cfg_src_ll, dst_ll: cfg_dst_ll, src_rl: cfg_src_rl,
                 dst_rl: cfg_dst_rl, stat_en: cfg_stat_en};

  assign stall_ok = cfg_int_en && !blk_mask;

  dmaseq_row_classify u_row (
    .cfg_i     (cfg),
    .row_o     (row),
    .kind_o    (kind),
    .stat_wb_o (stat_wb)
  );

  dmaseq_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start),
    .dst_done_i   (blk_dst_done),
    .clr_i        (clr_blk),
    .ack_i        (status_ack),
    .kind_i       (kind),
    .stat_wb_i    (stat_wb),
    .stall_ok_i   (stall_ok),
    .blk_end_o    (blk_end),
    .blk_start_o  (blk_start),
    .stalled_o    (stalled),
    .status_req_o (status_req),
    .done_o       (xfer_done),
    .active_o     (ch_active)
  );

  dmaseq_irq_flag u_irq (
    .clk        (clk),
    .rst_n      (rst_n),
    .blk_end_i  (blk_end),
    .src_done_i (blk_src_done),
    .int_en_i   (cfg_int_en),
    .mask_i     (blk_mask),
    .clr_i      (clr_blk),
    .pend_o     (pend),
    .irq_o      (blk_irq)
  );

  assign mode_row = row;

  // R1: the row always lies in the defined range
  p_row_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_row >= row_t'(1)) && (mode_row <= row_t'(ROW_MAX)));

  // R6: while stalled with interrupts still enabled and unmasked, the interrupt is visible
  p_stall_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(stalled) && stall_ok) |-> pend);
endmodule

// File: tb/dmaseq_channel_bench.sv
module dmaseq_channel_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 0, src_ll = 0, dst_ll = 0, src_rl = 0, dst_rl = 0, stat_en = 0;
  logic int_en = 0, mask = 0, src_done = 0, dst_done = 0, clr = 0, ack = 0;
  logic blk_start, stalled, status_req, xfer_done, ch_active, blk_irq;
  logic [3:0] mode_row;
  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  dmaseq_channel u_dmaseq_channel (
    .clk(clk), .rst_n(rst_n), .start(start),
    .cfg_src_ll(src_ll), .cfg_dst_ll(dst_ll), .cfg_src_rl(src_rl), .cfg_dst_rl(dst_rl),
    .cfg_stat_en(stat_en), .cfg_int_en(int_en), .blk_mask(mask),
    .blk_src_done(src_done), .blk_dst_done(dst_done), .clr_blk(clr), .status_ack(ack),
    .blk_start(blk_start), .stalled(stalled), .status_req(status_req),
    .xfer_done(xfer_done), .ch_active(ch_active), .blk_irq(blk_irq), .mode_row(mode_row)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic pulse(ref logic sig);
    sig = 1'b1; tick(); sig = 1'b0;
  endtask

  function automatic int exp_row(bit sl, bit dl, bit sr, bit dr, bit st);
    if (!sl && !dl) begin
      if (!sr && !dr) return st ? 5 : 1;
      if (dr && !sr) return 2;
      if (sr && !dr) return 3;
      return 4;
    end
    if (dl && !sl) begin
      if (!sr && !dr) return 6;
      if (sr && !dr) return 7;
      return 1;
    end
    if (sl && !dl) begin
      if (!sr && !dr) return 8;
      if (dr && !sr) return 9;
      return 1;
    end
    if (!sr && !dr) return 10;
    return 1;
  endfunction

  task automatic set_cfg(logic [4:0] c);
    {src_ll, dst_ll, src_rl, dst_rl, stat_en} = c;
  endtask

  // Finish a running or stalled transfer through row 1 and empty the interrupt.
  task automatic drain();
    if (status_req) begin pulse(ack); tick(); end
    else if (stalled || ch_active) begin
      set_cfg(5'b00000);
      if (stalled) pulse(clr);
      pulse(dst_done); tick(); tick();
    end else if (xfer_done) tick();
    pulse(clr);
    chk("R10 idle clear", blk_irq, 0);
    chk("R2 idle", ch_active, 0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      finished = 1;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    tick(); tick();
    // R12 reset state
    chk("R12 blk_start", blk_start, 0); chk("R12 stalled", stalled, 0);
    chk("R12 status_req", status_req, 0); chk("R12 done", xfer_done, 0);
    chk("R12 active", ch_active, 0); chk("R12 irq", blk_irq, 0);
    rst_n = 1'b1; tick();
    chk("R12 active after release", ch_active, 0);

    // Sweep: every configuration with every enable/mask pair.
    for (int c = 0; c < 32; c++) begin
      for (int e = 0; e < 4; e++) begin
        int row;
        bit ie, mk;
        ie = e[1]; mk = e[0];
        set_cfg(c[4:0]); int_en = ie; mask = mk;
        row = exp_row(c[4], c[3], c[2], c[1], c[0]);
        tick();
        chk((row == 1) ? "R11 row" : "R1 row", mode_row, row);
        pulse(start);
        chk("R4 first start", blk_start, 1);
        chk("R2 active", ch_active, 1);
        pulse(src_done);
        chk("R8 src only", blk_irq, 0);
        pulse(dst_done);
        chk("R8 dst irq", blk_irq, (ie && !mk) ? 1 : 0);
        tick();
        if (row == 1) begin
          chk("R2 done", xfer_done, 1); chk("R3 no status", status_req, 0);
          chk("R2 active drop", ch_active, 0);
          tick(); chk("R2 single pulse", xfer_done, 0);
        end else if (row == 5) begin
          chk("R3 status", status_req, 1); chk("R3 not done", xfer_done, 0);
          tick(); chk("R3 held", status_req, 1);
          pulse(ack);
          chk("R3 done after ack", xfer_done, 1);
          tick(); chk("R2 single pulse", xfer_done, 0);
        end else if (row == 6 || row == 8 || row == 10) begin
          chk("R4 continue", blk_start, 1); chk("R4 no stall", stalled, 0);
        end else if (ie && !mk) begin
          chk("R5 stall", stalled, 1); chk("R5 no start", blk_start, 0);
          tick(); tick(); chk("R6 still stalled", stalled, 1);
          pulse(clr);
          chk("R6 irq cleared", blk_irq, 0); chk("R6 start", blk_start, 1);
          chk("R6 left stall", stalled, 0);
        end else begin
          chk("R7 continue", blk_start, 1); chk("R7 no stall", stalled, 0);
        end
        drain();
      end
    end

    // R9: reload-only rows repeat until both reload bits are cleared.
    set_cfg(5'b00110); int_en = 1; mask = 1; tick();
    pulse(start);
    for (int b = 0; b < 3; b++) begin
      pulse(dst_done); tick();
      chk("R9 repeat both", blk_start, 1);
    end
    src_rl = 0; pulse(dst_done); tick();
    chk("R9 repeat dst only", blk_start, 1);
    chk("R9 row", mode_row, 2);
    dst_rl = 0; pulse(dst_done); tick();
    chk("R9 terminate", xfer_done, 1);
    drain();

    // R10: a clear strobe mid-block only drops the pending interrupt.
    set_cfg(5'b10000); int_en = 1; mask = 0; tick();
    pulse(start); pulse(dst_done); tick();
    chk("R10 irq set", blk_irq, 1); chk("R10 continued", blk_start, 1);
    tick();
    pulse(clr);
    chk("R10 irq cleared", blk_irq, 0); chk("R10 active", ch_active, 1);
    chk("R10 no start", blk_start, 0); chk("R10 no stall", stalled, 0);
    pulse(dst_done); tick();
    chk("R10 next block still continues", blk_start, 1);
    drain();

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule